// File: doc/BRIEF.md
# NAND Flash Host Interface

This block sits between a processor's register bus and a raw NAND flash device with an 8-bit data path. Software drives the flash command, address and data phases by setting pin levels in a control register and then moving bytes through a single data port. The block latches the command-latch, address-latch, write-protect and chip-enable outputs from the control register, and it shows the live ready/busy pin when that register is read.

Each byte that passes through the data port goes into a 256-byte Hamming accumulator, whichever way it travels. The accumulator keeps six column-parity bits, two line-parity bytes and a byte index. Software reads the line parity through two registers whose bits interleave the two parity bytes. A wide (32-bit) read of the data port pulls two flash bytes and places them in separate half-word lanes, so one bus access fetches a pair of bytes.

The bus side is a single-request protocol. The requester pulses `regReq` with the address, direction, width and write data, then waits for the one-cycle `regDone` pulse before it issues the next request. Read data is valid while `regDone` is high.

Top module: `nand_host_if`

## Requirements
- R1: After reset the control register is zero, so the command-latch, address-latch, write-protect and chip-enable outputs are low, and the column parity, both line-parity views and the byte counter all read zero.
- R2: A write to the control register (offset 0x18) stores data bits [7:0] with bit 5 forced to zero. From the next cycle the command-latch output follows bit 1, the address-latch output follows bit 2, the write-protect output follows bit 3, and the chip-enable output is high when bit 0 or bit 4 is set.
- R3: A read of the control register returns the stored value with bit 5 replaced by the level of the ready/busy pin at the time of the request.
- R4: A write to the data port (offset 0x14) puts data bits [7:0] on the flash data output and raises the flash write strobe for exactly the one cycle after the request. The byte is fed to the ECC accumulator. No other request raises the write strobe.
- R5: A narrow read of the data port raises the flash read strobe for one cycle and captures the flash byte into bits [7:0], with all other bits zero. `regDone` comes two cycles after the request. The byte is fed to the ECC accumulator.
- R6: A wide read of the data port raises the read strobe for two consecutive cycles. The first byte goes to bits [7:0] and the second to bits [23:16], and all other bits are zero. `regDone` comes three cycles after the request. Both bytes are fed to the accumulator in order.
- R7: The counter register (offset 0x0C) returns the low 8 bits of the number of bytes fed since the last clear, in both directions, and it wraps to zero after 256 bytes.
- R8: The column-parity register (offset 0x08) returns six bits. For level j in 0..2, bit 2j+1 is the running XOR of data bits whose bit index has bit j set, and bit 2j is the running XOR of data bits whose bit index has bit j clear. Bits above 5 are zero.
- R9: Let P1 be the XOR of the indices of all odd-parity bytes, and P0 the XOR of their complements. The register at 0x00 returns P0[4+k] in bit 2k and P1[4+k] in bit 2k+1. The register at 0x04 returns P0[k] in bit 2k and P1[k] in bit 2k+1, for k = 0..3.
- R10: A write of any data to the clear register (offset 0x10) zeroes the parity and the counter. It leaves the control register and the flash pins unchanged.
- R11: A read of an undefined offset returns zero. A write to an undefined offset, or to the parity or counter registers, changes neither the control register nor the ECC state.
- R12: Every request other than a data-port read gets exactly one `regDone` pulse, in the cycle after the request. `regDone` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regReq | input | 1 | One-cycle request pulse |
| regWrite | input | 1 | 1 = write request, 0 = read request |
| regWide | input | 1 | 1 = 32-bit access (two flash bytes on a data-port read) |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Write data; bits [7:0] are used |
| regRdata | output | 32 | Read data, valid while regDone is high |
| regDone | output | 1 | Request completion pulse |
| flashIoIn | input | 8 | Byte presented by the flash |
| flashIoOut | output | 8 | Byte driven to the flash |
| flashWrStrobe | output | 1 | Flash write strobe, one cycle per byte |
| flashRdStrobe | output | 1 | Flash read strobe; the flash byte is taken at the end of this cycle |
| flashCe | output | 1 | Chip enable |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashWp | output | 1 | Write protect |
| flashRyBy | input | 1 | Ready/busy level from the flash |

## Verification
Four behaviours are checked by assertions on every cycle:
- the one-cycle completion of register accesses and the single-cycle `regDone`;
- the pin levels that follow a control write;
- the coupling between data-port writes and the write strobe;
- the read-strobe counts for narrow and wide reads, and the zero lanes in read data.

Other behaviours only show up across a whole sequence of bytes, so only the bench scenarios can expose them:
- the accuracy of the parity bits;
- the interleaved line-parity views;
- counter wrap at 256;
- the effect of clear;
- the order in which the two wide-read bytes land.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

  localparam int REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] OFS_LP_LO = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_LP_HI = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_COLP  = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_CNT   = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_CLR   = 5'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_IO    = 5'h14;
  localparam logic [REG_ADDR_W-1:0] OFS_CTL   = 5'h18;

  // control register bit positions
  localparam int CTL_CE0 = 0;
  localparam int CTL_CLE = 1;
  localparam int CTL_ALE = 2;
  localparam int CTL_WP  = 3;
  localparam int CTL_CE1 = 4;
  localparam int CTL_RDY = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic ctlWr;     // load control register
    logic eccClr;    // clear accumulator
    logic ioWr;      // drive a byte to flash
    logic ioCap;     // capture a flash byte
    logic capHigh;   // capture into upper half-word lane
    logic regLatch;  // latch a register value into read data
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RD_FIRST  = 2'd1,
    ST_RD_SECOND = 2'd2
  } hostState_t;

endpackage

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int BYTE_W      = 8,
  parameter int BLOCK_BYTES = 256,
  localparam int IDX_W      = $clog2(BLOCK_BYTES),
  localparam int COL_LVL    = $clog2(BYTE_W),
  localparam int COL_W      = 2 * COL_LVL
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              feed,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [IDX_W-1:0]  lpEven,
  output logic [IDX_W-1:0]  lpOdd,
  output logic [COL_W-1:0]  colPar,
  output logic [IDX_W-1:0]  byteIdx
);

  logic [COL_W-1:0] colTerm;
  logic             rowOdd;

  // column contribution of one byte: split bit positions by each index bit
  always_comb begin
    colTerm = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      for (int j = 0; j < COL_LVL; j++) begin
        if (b[j]) colTerm[2*j+1] = colTerm[2*j+1] ^ dataIn[b];
        else      colTerm[2*j]   = colTerm[2*j]   ^ dataIn[b];
      end
    end
  end

  assign rowOdd = ^dataIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lpEven  <= '0;
      lpOdd   <= '0;
      colPar  <= '0;
      byteIdx <= '0;
    end else if (clr) begin
      lpEven  <= '0;
      lpOdd   <= '0;
      colPar  <= '0;
      byteIdx <= '0;
    end else if (feed) begin
      colPar  <= colPar ^ colTerm;
      byteIdx <= byteIdx + 1'b1;
      if (rowOdd) begin
        lpOdd  <= lpOdd ^ byteIdx;
        lpEven <= lpEven ^ ~byteIdx;
      end
    end
  end

endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nand_host_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regReq,
  input  logic                  regWrite,
  input  logic                  regWide,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output ctlStrobes_t           strobes,
  output logic                  flashRdStrobe,
  output logic                  regDone
);

  hostState_t state, nextState;
  logic       wideHeld;
  logic       doneNext;

  always_comb begin
    strobes   = '0;
    nextState = state;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (regReq) begin
          if (regWrite) begin
            doneNext = 1'b1;
            case (regAddr)
              OFS_CTL: strobes.ctlWr  = 1'b1;
              OFS_CLR: strobes.eccClr = 1'b1;
              OFS_IO:  strobes.ioWr   = 1'b1;
              default: ;
            endcase
          end else if (regAddr == OFS_IO) begin
            nextState = ST_RD_FIRST;
          end else begin
            strobes.regLatch = 1'b1;
            doneNext         = 1'b1;
          end
        end
      end
      ST_RD_FIRST: begin
        strobes.ioCap = 1'b1;
        if (wideHeld) begin
          nextState = ST_RD_SECOND;
        end else begin
          nextState = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      ST_RD_SECOND: begin
        strobes.ioCap   = 1'b1;
        strobes.capHigh = 1'b1;
        nextState       = ST_IDLE;
        doneNext        = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign flashRdStrobe = (state == ST_RD_FIRST) || (state == ST_RD_SECOND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wideHeld <= 1'b0;
      regDone  <= 1'b0;
    end else begin
      state   <= nextState;
      regDone <= doneNext;
      if (state == ST_IDLE && regReq) wideHeld <= regWide;
    end
  end

endmodule

// File: rtl/nand_host_dpath.sv
module nand_host_dpath
  import nand_host_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int BYTE_W      = 8,
  parameter int BLOCK_BYTES = 256,
  localparam int IDX_W      = $clog2(BLOCK_BYTES),
  localparam int HALF_IDX   = IDX_W / 2,
  localparam int COL_W      = 2 * $clog2(BYTE_W),
  localparam int LANE_HI    = BUS_W / 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0]     wrByte,
  input  logic [BYTE_W-1:0]     flashIoIn,
  input  logic                  flashRyBy,
  output logic [BUS_W-1:0]      regRdata,
  output logic [BYTE_W-1:0]     flashIoOut,
  output logic                  flashWrStrobe,
  output logic                  flashCe,
  output logic                  flashCle,
  output logic                  flashAle,
  output logic                  flashWp
);

  logic [BYTE_W-1:0] ctlReg;
  logic [BYTE_W-1:0] ctlNext;
  logic [BYTE_W-1:0] ctlView;
  logic [IDX_W-1:0]  lpEven, lpOdd, byteIdx;
  logic [COL_W-1:0]  colPar;
  logic [IDX_W-1:0]  lpLoView, lpHiView;
  logic [BUS_W-1:0]  regValue;
  logic              eccFeed;
  logic [BYTE_W-1:0] eccByte;

  assign eccFeed = strobes.ioWr | strobes.ioCap;
  assign eccByte = strobes.ioWr ? wrByte : flashIoIn;

  nand_ecc_acc #(
    .BYTE_W     (BYTE_W),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) uEcc (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (strobes.eccClr),
    .feed   (eccFeed),
    .dataIn (eccByte),
    .lpEven (lpEven),
    .lpOdd  (lpOdd),
    .colPar (colPar),
    .byteIdx(byteIdx)
  );

  // interleave the two parity bytes into the readback views
  for (genvar k = 0; k < HALF_IDX; k++) begin : gInterleave
    assign lpLoView[2*k]   = lpEven[HALF_IDX+k];
    assign lpLoView[2*k+1] = lpOdd[HALF_IDX+k];
    assign lpHiView[2*k]   = lpEven[k];
    assign lpHiView[2*k+1] = lpOdd[k];
  end

  always_comb begin
    ctlNext          = wrByte;
    ctlNext[CTL_RDY] = 1'b0;
    ctlView          = ctlReg;
    ctlView[CTL_RDY] = flashRyBy;
  end

  always_comb begin
    regValue = '0;
    case (regAddr)
      OFS_LP_LO: regValue[IDX_W-1:0]  = lpLoView;
      OFS_LP_HI: regValue[IDX_W-1:0]  = lpHiView;
      OFS_COLP:  regValue[COL_W-1:0]  = colPar;
      OFS_CNT:   regValue[IDX_W-1:0]  = byteIdx;
      OFS_CTL:   regValue[BYTE_W-1:0] = ctlView;
      default:   regValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg        <= '0;
      flashIoOut    <= '0;
      flashWrStrobe <= 1'b0;
      regRdata      <= '0;
    end else begin
      flashWrStrobe <= strobes.ioWr;
      if (strobes.ctlWr) ctlReg     <= ctlNext;
      if (strobes.ioWr)  flashIoOut <= wrByte;
      if (strobes.regLatch) begin
        regRdata <= regValue;
      end else if (strobes.ioCap) begin
        if (strobes.capHigh) begin
          regRdata[LANE_HI +: BYTE_W] <= flashIoIn;
        end else begin
          regRdata               <= '0;
          regRdata[BYTE_W-1:0]   <= flashIoIn;
        end
      end
    end
  end

  assign flashCe  = ctlReg[CTL_CE0] | ctlReg[CTL_CE1];
  assign flashCle = ctlReg[CTL_CLE];
  assign flashAle = ctlReg[CTL_ALE];
  assign flashWp  = ctlReg[CTL_WP];

endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
  import nand_host_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int BYTE_W      = 8,
  parameter int BLOCK_BYTES = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regReq,
  input  logic                  regWrite,
  input  logic                  regWide,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]      regWdata,
  output logic [BUS_W-1:0]      regRdata,
  output logic                  regDone,
  input  logic [BYTE_W-1:0]     flashIoIn,
  output logic [BYTE_W-1:0]     flashIoOut,
  output logic                  flashWrStrobe,
  output logic                  flashRdStrobe,
  output logic                  flashCe,
  output logic                  flashCle,
  output logic                  flashAle,
  output logic                  flashWp,
  input  logic                  flashRyBy
);

  ctlStrobes_t strobes;
  logic        unusedWdataHi;

  assign unusedWdataHi = ^regWdata[BUS_W-1:BYTE_W];

  nand_host_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .regReq       (regReq),
    .regWrite     (regWrite),
    .regWide      (regWide),
    .regAddr      (regAddr),
    .strobes      (strobes),
    .flashRdStrobe(flashRdStrobe),
    .regDone      (regDone)
  );

  nand_host_dpath #(
    .BUS_W      (BUS_W),
    .BYTE_W     (BYTE_W),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regAddr      (regAddr),
    .wrByte       (regWdata[BYTE_W-1:0]),
    .flashIoIn    (flashIoIn),
    .flashRyBy    (flashRyBy),
    .regRdata     (regRdata),
    .flashIoOut   (flashIoOut),
    .flashWrStrobe(flashWrStrobe),
    .flashCe      (flashCe),
    .flashCle     (flashCle),
    .flashAle     (flashAle),
    .flashWp      (flashWp)
  );

endmodule

// File: rtl/nand_host_chk.sv
module nand_host_chk
  import nand_host_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8,
  localparam int LANE_HI = BUS_W / 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regReq,
  input logic                  regWrite,
  input logic                  regWide,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [BUS_W-1:0]      regWdata,
  input logic [BUS_W-1:0]      regRdata,
  input logic                  regDone,
  input logic [BYTE_W-1:0]     flashIoOut,
  input logic                  flashWrStrobe,
  input logic                  flashRdStrobe,
  input logic                  flashCe,
  input logic                  flashCle,
  input logic                  flashAle,
  input logic                  flashWp
);

  logic ioRead;
  assign ioRead = regReq && !regWrite && (regAddr == OFS_IO);

  assert_reg_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !ioRead) |=> regDone);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    regDone |=> !regDone);

  assert_ctl_pins_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWrite && regAddr == OFS_CTL) |=>
      (flashCle == $past(regWdata[CTL_CLE]) && flashAle == $past(regWdata[CTL_ALE]) &&
       flashWp == $past(regWdata[CTL_WP]) &&
       flashCe == ($past(regWdata[CTL_CE0]) | $past(regWdata[CTL_CE1]))));

  assert_io_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWrite && regAddr == OFS_IO) |=>
      (flashWrStrobe && flashIoOut == $past(regWdata[BYTE_W-1:0])));

  assert_wr_strobe_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    flashWrStrobe |-> $past(regReq && regWrite && regAddr == OFS_IO));

  assert_rd_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    ioRead |=> (flashRdStrobe && !flashWrStrobe));

  assert_narrow_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ioRead && !regWide) |=> ##1 (!flashRdStrobe && regDone));

  assert_wide_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ioRead && regWide) |=> ##1 (flashRdStrobe && !regDone));

  assert_lanes_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    regDone |-> (regRdata[BUS_W-1:LANE_HI+BYTE_W] == '0 &&
                 regRdata[LANE_HI-1:BYTE_W] == '0));

endmodule

bind nand_host_if nand_host_chk #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .regReq       (regReq),
  .regWrite     (regWrite),
  .regWide      (regWide),
  .regAddr      (regAddr),
  .regWdata     (regWdata),
  .regRdata     (regRdata),
  .regDone      (regDone),
  .flashIoOut   (flashIoOut),
  .flashWrStrobe(flashWrStrobe),
  .flashRdStrobe(flashRdStrobe),
  .flashCe      (flashCe),
  .flashCle     (flashCle),
  .flashAle     (flashAle),
  .flashWp      (flashWp)
);

// File: tb/tb_nand_host_if.sv
module tb_nand_host_if;

  localparam logic [4:0] A_LPLO = 5'h00, A_LPHI = 5'h04, A_COLP = 5'h08, A_CNT = 5'h0C;
  localparam logic [4:0] A_CLR = 5'h10, A_IO = 5'h14, A_CTL = 5'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regReq = 1'b0, regWrite = 1'b0, regWide = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regDone;
  logic [7:0]  flashIoIn;
  logic [7:0]  flashIoOut;
  logic        flashWrStrobe, flashRdStrobe, flashCe, flashCle, flashAle, flashWp;
  logic        flashRyBy = 1'b0;

  always #10 clk = ~clk;

  nand_host_if dut (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWrite(regWrite), .regWide(regWide),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regDone(regDone),
    .flashIoIn(flashIoIn), .flashIoOut(flashIoOut), .flashWrStrobe(flashWrStrobe),
    .flashRdStrobe(flashRdStrobe), .flashCe(flashCe), .flashCle(flashCle),
    .flashAle(flashAle), .flashWp(flashWp), .flashRyBy(flashRyBy)
  );

  // flash model: byte stream advanced by the read strobe
  logic [7:0] rdMem [0:255];
  logic [7:0] rdPtr = '0;
  assign flashIoIn = rdMem[rdPtr];
  always @(posedge clk) if (flashRdStrobe) rdPtr <= rdPtr + 8'd1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench ECC model
  logic [7:0] bLp0 = '0, bLp1 = '0, bIdx = '0;
  logic [5:0] bCp = '0;
  logic [7:0] bCtl = '0;
  logic [7:0] expPtr = '0;

  task automatic modelFeed(input logic [7:0] d);
    for (int b = 0; b < 8; b++) begin
      if (d[b]) begin
        for (int j = 0; j < 3; j++) begin
          if (((b >> j) & 1) == 1) bCp[2*j+1] = ~bCp[2*j+1];
          else                     bCp[2*j]   = ~bCp[2*j];
        end
      end
    end
    if (^d) begin
      bLp1 = bLp1 ^ bIdx;
      bLp0 = bLp0 ^ ~bIdx;
    end
    bIdx = bIdx + 8'd1;
  endtask

  task automatic modelClear();
    bLp0 = '0; bLp1 = '0; bIdx = '0; bCp = '0;
  endtask

  function automatic logic [31:0] expLpLo();
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      r[2*k] = bLp0[4+k];
      r[2*k+1] = bLp1[4+k];
    end
    return r;
  endfunction

  function automatic logic [31:0] expLpHi();
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      r[2*k] = bLp0[k];
      r[2*k+1] = bLp1[k];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic wide, input logic [4:0] addr,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    regReq = 1'b1; regWrite = wr; regWide = wide; regAddr = addr; regWdata = wd;
    @(negedge clk);
    regReq = 1'b0; regWrite = 1'b0; regWide = 1'b0;
    lat = 1;
    while (!regDone && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = regRdata;
  endtask

  task automatic writeReg(input logic [4:0] addr, input logic [31:0] wd, input string req);
    logic [31:0] rd;
    int lat;
    busOp(1'b1, 1'b0, addr, wd, rd, lat);
    check({req, " write latency"}, lat, 1);
    if (addr == A_IO) begin
      check({req, " write strobe"}, {31'd0, flashWrStrobe}, 1);
      check({req, " flash byte out"}, {24'd0, flashIoOut}, {24'd0, wd[7:0]});
      modelFeed(wd[7:0]);
    end else if (addr == A_CTL) begin
      bCtl = wd[7:0];
      bCtl[5] = 1'b0;
    end else if (addr == A_CLR) begin
      modelClear();
    end
  endtask

  task automatic readEcc(input string req);
    logic [31:0] rd;
    int lat;
    busOp(1'b0, 1'b0, A_LPLO, '0, rd, lat);
    check({req, " R9 line parity low view"}, rd, expLpLo());
    busOp(1'b0, 1'b0, A_LPHI, '0, rd, lat);
    check({req, " R9 line parity high view"}, rd, expLpHi());
    busOp(1'b0, 1'b0, A_COLP, '0, rd, lat);
    check({req, " R8 column parity"}, rd, {26'd0, bCp});
    busOp(1'b0, 1'b0, A_CNT, '0, rd, lat);
    check({req, " R7 byte counter"}, rd, {24'd0, bIdx});
  endtask

  task automatic readCtl(input string req);
    logic [31:0] rd;
    int lat;
    logic [7:0] e;
    busOp(1'b0, 1'b0, A_CTL, '0, rd, lat);
    e = bCtl;
    e[5] = flashRyBy;
    check({req, " R3 control readback"}, rd, {24'd0, e});
    check({req, " R12 read latency"}, lat, 1);
    check({req, " R2 pins"}, {28'd0, flashCe, flashCle, flashAle, flashWp},
          {28'd0, bCtl[0] | bCtl[4], bCtl[1], bCtl[2], bCtl[3]});
  endtask

  task automatic ioRead(input logic wide, input string req);
    logic [31:0] rd;
    int lat;
    logic [31:0] e;
    busOp(1'b0, wide, A_IO, '0, rd, lat);
    e = '0;
    e[7:0] = rdMem[expPtr];
    modelFeed(rdMem[expPtr]);
    expPtr = expPtr + 8'd1;
    if (wide) begin
      e[23:16] = rdMem[expPtr];
      modelFeed(rdMem[expPtr]);
      expPtr = expPtr + 8'd1;
      check({req, " R6 wide data"}, rd, e);
      check({req, " R6 wide latency"}, lat, 3);
    end else begin
      check({req, " R5 narrow data"}, rd, e);
      check({req, " R5 narrow latency"}, lat, 2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 256; i++) rdMem[i] = 8'($urandom);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pins after reset", {28'd0, flashCe, flashCle, flashAle, flashWp}, 32'd0);
    check("R1 write strobe idle", {31'd0, flashWrStrobe}, 32'd0);
    readCtl("R1");
    readEcc("R1");

    // R2 / R3 directed control patterns
    writeReg(A_CTL, 32'hFFFF_FFFF, "R2 all ones");
    readCtl("R2 all ones bit5 cleared");
    writeReg(A_CTL, 32'h0000_0010, "R2 second enable only");
    readCtl("R2 CE from bit4");
    writeReg(A_CTL, 32'h0000_0001, "R2 first enable only");
    readCtl("R2 CE from bit0");
    writeReg(A_CTL, 32'h0000_000A, "R2 cle and wp");
    flashRyBy = 1'b1;
    readCtl("R3 ready high");
    flashRyBy = 1'b0;
    readCtl("R3 ready low");

    // R4/R7/R8/R9 directed bytes
    writeReg(A_IO, 32'h0000_0001, "R4 single bit");
    writeReg(A_IO, 32'h0000_0080, "R4 top bit");
    writeReg(A_IO, 32'h0000_00FF, "R4 even byte");
    readEcc("R8 directed");
    ioRead(1'b0, "R5 narrow");
    ioRead(1'b1, "R6 wide");
    readEcc("R9 after reads");

    // R10 clear with arbitrary data keeps control
    writeReg(A_CTL, 32'h0000_0016, "R10 setup control");
    writeReg(A_CLR, 32'hDEAD_BEEF, "R10 clear");
    readEcc("R10 after clear");
    readCtl("R10 control kept");

    // R11 undefined offsets and read-only registers
    writeReg(A_IO, 32'h0000_0037, "R11 seed ecc");
    busOp(1'b0, 1'b0, 5'h1C, '0, rd, lat);
    check("R11 undefined read 0x1C", rd, 32'd0);
    busOp(1'b0, 1'b1, 5'h02, '0, rd, lat);
    check("R11 undefined read 0x02", rd, 32'd0);
    writeReg(5'h1C, 32'hFFFF_FFFF, "R11 undefined write");
    writeReg(A_CNT, 32'h0000_00FF, "R11 counter write");
    writeReg(A_LPLO, 32'h0000_00FF, "R11 parity write");
    readEcc("R11 ecc unchanged");
    readCtl("R11 control unchanged");

    // R7 counter wrap after 256 bytes
    writeReg(A_CLR, 32'd0, "R7 clear before wrap");
    for (int i = 0; i < 259; i++) writeReg(A_IO, 32'($urandom), "R7 wrap fill");
    readEcc("R7 wrapped");
    check("R7 wrapped count", {24'd0, bIdx}, 32'd3);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: writeReg(A_IO, 32'($urandom), "R4 random write");
        2: ioRead(1'b0, "R5 random");
        3: ioRead(1'b1, "R6 random");
        4: readEcc("R8 R9 random");
        5: if ($urandom_range(0, 3) == 0) writeReg(A_CLR, 32'($urandom), "R10 random clear");
        6: begin
          flashRyBy = 1'($urandom);
          writeReg(A_CTL, 32'($urandom), "R2 random control");
          readCtl("R3 random");
        end
        7: begin
          busOp(1'b0, 1'($urandom), 5'h1C, '0, rd, lat);
          check("R11 random undefined read", rd, 32'd0);
          check("R12 random latency", lat, 1);
        end
        default: writeReg(A_IO, {24'd0, 8'($urandom_range(0, 3))}, "R4 sparse write");
      endcase
    end
    readEcc("final");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule